// File: doc/BRIEF.md
# Sized Integer Multiplier with Full Status Flags

This unit performs the integer multiply operations of a legacy 32-bit accumulator architecture. It supports 8-bit, 16-bit and 32-bit operand sizes, in signed and unsigned variants. In the accumulator form, the unit multiplies the low part of the accumulator by a source operand. The double-width product is then merged into the accumulator and data registers according to the operand size. Register bits above the operand size are left untouched.

The unit also has a two-operand form. This form is always signed. It returns only the product truncated to the operand width on a destination output. In this form the first factor is taken from the accumulator input, and both register outputs echo their inputs unchanged.

Every operation also produces a complete 16-bit status flags word. All arithmetic flags are derived from the product, not just carry and overflow. The datapath is combinational. One request strobe loads a registered output stage, and a valid strobe follows one cycle later.

Top module: `imul_unit`

## Requirements
- R1: With size code 0 (byte) in the accumulator form, the 16-bit product of acc_i[7:0] and src_i[7:0] replaces acc_o[15:0]; acc_o[31:16] keeps acc_i[31:16], and dat_o equals dat_i.
- R2: With size code 1 (word) in the accumulator form, product bits 15:0 go to acc_o[15:0] and product bits 31:16 go to dat_o[15:0]; the upper 16 bits of both registers keep their input values.
- R3: With size code 2 or 3 (doubleword) in the accumulator form, acc_o receives product bits 31:0 and dat_o receives product bits 63:32.
- R4: For an unsigned multiply (signed_i = 0, accumulator form), carry (flags bit 0) and overflow (flags bit 11) are both 1 exactly when the upper half of the double-width product is nonzero.
- R5: For a signed multiply, carry and overflow are both 1 exactly when the full product differs from the sign extension of its low operand-width bits.
- R6: Parity (flags bit 2) is 1 when the low 8 bits of the product hold an even number of ones.
- R7: Zero (flags bit 6) is 1 when the product truncated to the operand width is zero; sign (flags bit 7) equals product bit (operand width - 1); res_o carries that truncated product, zero-extended to 32 bits, in both forms.
- R8: Auxiliary carry (flags bit 4) and every flags bit other than 0, 2, 6, 7 and 11 are always 0.
- R9: With form_i = 1 (two-operand form), the multiply is signed whatever signed_i is, a byte size code is treated as word, res_o holds the truncated product, and acc_o and dat_o equal acc_i and dat_i.
- R10: valid_o is 1 in exactly the cycle after a cycle with req_i = 1; when req_i = 0, all result outputs hold their values.
- R11: While rst_n is low, valid_o, acc_o, dat_o, res_o and flags_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; loads the output stage |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 doubleword |
| signed_i | input | 1 | 1 selects signed multiply |
| form_i | input | 1 | 0 selects the accumulator form, 1 the two-operand form |
| acc_i | input | 32 | Accumulator value (the first factor) |
| dat_i | input | 32 | Data register value |
| src_i | input | 32 | Source operand (the second factor) |
| valid_o | output | 1 | Result valid, one cycle after req_i |
| acc_o | output | 32 | Updated accumulator |
| dat_o | output | 32 | Updated data register |
| res_o | output | 32 | Truncated product, zero-extended |
| flags_o | output | 16 | Status flags word |

## Verification
Small positive operands give products that fit in the operand width, with overflow clear. Operands whose product spills into the upper half separate the unsigned test (any upper bit set) from the signed test (upper bits not a copy of the sign bit). Operands that are all ones act as the largest value when unsigned and as -1 when signed. The most negative value times -1 overflows only in the signed reading. A zero operand exposes the zero and parity flags. Nonzero upper register bits show whether the partial-register merge keeps the bits outside the operand size. A two-operand request with signed_i = 0 and a byte size code shows whether the form overrides signedness and size.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_WIDE  = 2'd3
  } opsize_e;

  localparam int NUM_SIZES = 3;
  localparam int FLAGS_W   = 16;

  localparam int FL_CF = 0;
  localparam int FL_PF = 2;
  localparam int FL_AF = 4;
  localparam int FL_ZF = 6;
  localparam int FL_SF = 7;
  localparam int FL_OF = 11;

  // Index into the per-size candidate arrays: 0 byte, 1 word, 2 doubleword.
  function automatic logic [1:0] size_index(input opsize_e sz);
    return (sz == SZ_WIDE) ? 2'd2 : 2'(sz);
  endfunction

endpackage

// File: rtl/imul_operand_ext.sv
module imul_operand_ext
  import imul_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW  = 2 * XLEN
) (
  input  logic [1:0]      sel_i,
  input  logic            sgn_i,
  input  logic [XLEN-1:0] val_i,
  output logic [PW-1:0]   ext_o
);

  logic [PW-1:0] cand [NUM_SIZES];

  // Build one candidate per operand width: sign- or zero-extended to PW bits.
  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_width
    localparam int W = XLEN >> (NUM_SIZES - 1 - i);
    logic fill;
    assign fill    = sgn_i & val_i[W-1];
    assign cand[i] = {{(PW-W){fill}}, val_i[W-1:0]};
  end

  always_comb begin
    case (sel_i)
      2'd0:    ext_o = cand[0];
      2'd1:    ext_o = cand[1];
      default: ext_o = cand[2];
    endcase
  end

endmodule

// File: rtl/imul_flag_gen.sv
module imul_flag_gen
  import imul_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW  = 2 * XLEN
) (
  input  logic [1:0]         sel_i,
  input  logic               sgn_i,
  input  logic [PW-1:0]      prod_i,
  output logic [FLAGS_W-1:0] flags_o
);

  logic [NUM_SIZES-1:0] ovf_c, zero_c, sign_c;

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_width
    localparam int W = XLEN >> (NUM_SIZES - 1 - i);
    logic [PW-W:0] top_s;   // bits W-1 .. PW-1
    logic [PW-W-1:0] top_u; // bits W .. PW-1
    assign top_s     = prod_i[PW-1:W-1];
    assign top_u     = prod_i[PW-1:W];
    assign ovf_c[i]  = sgn_i ? ~((&top_s) | ~(|top_s)) : (|top_u);
    assign zero_c[i] = ~(|prod_i[W-1:0]);
    assign sign_c[i] = prod_i[W-1];
  end

  logic ovf, zf, sf, pf;

  always_comb begin
    ovf = ovf_c[sel_i];
    zf  = zero_c[sel_i];
    sf  = sign_c[sel_i];
    pf  = ~(^prod_i[7:0]);
    flags_o        = '0;
    flags_o[FL_CF] = ovf;
    flags_o[FL_PF] = pf;
    flags_o[FL_AF] = 1'b0;
    flags_o[FL_ZF] = zf;
    flags_o[FL_SF] = sf;
    flags_o[FL_OF] = ovf;
  end

endmodule

// File: rtl/imul_writeback.sv
module imul_writeback
  import imul_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW  = 2 * XLEN,
  localparam int HW  = XLEN / 2
) (
  input  logic            two_op_i,
  input  logic [1:0]      sel_i,
  input  logic [XLEN-1:0] acc_i,
  input  logic [XLEN-1:0] dat_i,
  input  logic [PW-1:0]   prod_i,
  output logic [XLEN-1:0] acc_o,
  output logic [XLEN-1:0] dat_o,
  output logic [XLEN-1:0] res_o
);

  logic [XLEN-1:0] trunc_c [NUM_SIZES];

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_width
    localparam int W = XLEN >> (NUM_SIZES - 1 - i);
    if (W == XLEN) begin : g_full
      assign trunc_c[i] = prod_i[XLEN-1:0];
    end else begin : g_part
      assign trunc_c[i] = {{(XLEN-W){1'b0}}, prod_i[W-1:0]};
    end
  end

  always_comb begin
    res_o = trunc_c[sel_i];
    acc_o = acc_i;
    dat_o = dat_i;
    if (!two_op_i) begin
      case (sel_i)
        2'd0: begin
          acc_o = {acc_i[XLEN-1:HW], prod_i[HW-1:0]};
        end
        2'd1: begin
          acc_o = {acc_i[XLEN-1:HW], prod_i[HW-1:0]};
          dat_o = {dat_i[XLEN-1:HW], prod_i[XLEN-1:HW]};
        end
        default: begin
          acc_o = prod_i[XLEN-1:0];
          dat_o = prod_i[PW-1:XLEN];
        end
      endcase
    end
  end

endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [1:0]         size_i,
  input  logic               signed_i,
  input  logic               form_i,
  input  logic [XLEN-1:0]    acc_i,
  input  logic [XLEN-1:0]    dat_i,
  input  logic [XLEN-1:0]    src_i,
  output logic               valid_o,
  output logic [XLEN-1:0]    acc_o,
  output logic [XLEN-1:0]    dat_o,
  output logic [XLEN-1:0]    res_o,
  output logic [FLAGS_W-1:0] flags_o
);

  localparam int PW = 2 * XLEN;

  // Operation normalisation: two-operand form is signed and at least word-sized.
  logic [1:0] sel;
  logic       sgn;

  always_comb begin
    sel = size_index(opsize_e'(size_i));
    if (form_i && sel == 2'd0) sel = 2'd1;
    sgn = signed_i | form_i;
  end

  logic [PW-1:0] a_ext, b_ext, prod;

  imul_operand_ext #(.XLEN(XLEN)) u_ext_a (
    .sel_i(sel), .sgn_i(sgn), .val_i(acc_i), .ext_o(a_ext)
  );

  imul_operand_ext #(.XLEN(XLEN)) u_ext_b (
    .sel_i(sel), .sgn_i(sgn), .val_i(src_i), .ext_o(b_ext)
  );

  // Both factors are extended to PW bits, so the PW-bit product is exact.
  assign prod = a_ext * b_ext;

  logic [FLAGS_W-1:0] flags_n;

  imul_flag_gen #(.XLEN(XLEN)) u_flags (
    .sel_i(sel), .sgn_i(sgn), .prod_i(prod), .flags_o(flags_n)
  );

  logic [XLEN-1:0] acc_n, dat_n, res_n;

  imul_writeback #(.XLEN(XLEN)) u_wb (
    .two_op_i(form_i), .sel_i(sel), .acc_i(acc_i), .dat_i(dat_i),
    .prod_i(prod), .acc_o(acc_n), .dat_o(dat_n), .res_o(res_n)
  );

  // Output stage: clock enable is the request strobe.
  logic upd_en;
  assign upd_en = req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      acc_o   <= '0;
      dat_o   <= '0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= upd_en;
      if (upd_en) begin
        acc_o   <= acc_n;
        dat_o   <= dat_n;
        res_o   <= res_n;
        flags_o <= flags_n;
      end
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o); // R10
  AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(acc_o) && $stable(dat_o) && $stable(res_o) && $stable(flags_o))); // R10
  AST_CARRY_EQ_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (flags_o[FL_CF] == flags_o[FL_OF])); // R4 R5
  AST_UNUSED_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~((16'd1 << FL_CF) | (16'd1 << FL_PF) | (16'd1 << FL_ZF)
                 | (16'd1 << FL_SF) | (16'd1 << FL_OF))) == '0); // R8
  AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (flags_o[FL_ZF] == (res_o == '0))); // R7
  AST_TWO_OP_REGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && form_i) |=> (acc_o == $past(acc_i) && dat_o == $past(dat_i))); // R9
  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !form_i && size_i == 2'd0) |=>
      (acc_o[XLEN-1:XLEN/2] == $past(acc_i[XLEN-1:XLEN/2]) && dat_o == $past(dat_i))); // R1

endmodule

// File: tb/imul_unit_test.sv
module imul_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [1:0]  size_i;
  logic        signed_i;
  logic        form_i;
  logic [31:0] acc_i, dat_i, src_i;
  logic        valid_o;
  logic [31:0] acc_o, dat_o, res_o;
  logic [15:0] flags_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2ns clk = ~clk;

  imul_unit uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .size_i(size_i),
    .signed_i(signed_i), .form_i(form_i), .acc_i(acc_i), .dat_i(dat_i),
    .src_i(src_i), .valid_o(valid_o), .acc_o(acc_o), .dat_o(dat_o),
    .res_o(res_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference: exact product with 64-bit arithmetic on extended operands.
  task automatic run_op(input logic [1:0] sz, input logic sg, input logic fm,
                        input logic [31:0] a, input logic [31:0] d,
                        input logic [31:0] s);
    int w;
    logic eff_sg;
    logic [63:0] mask, ea, eb, p, trunc, sx;
    logic ov;
    logic [31:0] eacc, edat;
    string rreg, rov;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    if (fm && w == 8) w = 16;
    eff_sg = sg | fm;
    mask = (64'd1 << w) - 64'd1;
    ea = {32'd0, a} & mask;
    eb = {32'd0, s} & mask;
    if (eff_sg && ea[w-1]) ea = ea | ~mask;
    if (eff_sg && eb[w-1]) eb = eb | ~mask;
    p = ea * eb;
    trunc = p & mask;
    if (eff_sg) begin
      sx = trunc[w-1] ? (trunc | ~mask) : trunc;
      ov = (sx != p);
    end else begin
      ov = ((p & ~mask) != 64'd0);
    end
    if (fm) begin
      eacc = a; edat = d; rreg = "R9";
    end else if (w == 8) begin
      eacc = {a[31:16], p[15:0]}; edat = d; rreg = "R1";
    end else if (w == 16) begin
      eacc = {a[31:16], p[15:0]}; edat = {d[31:16], p[31:16]}; rreg = "R2";
    end else begin
      eacc = p[31:0]; edat = p[63:32]; rreg = "R3";
    end
    rov = eff_sg ? "R5" : "R4";

    @(negedge clk);
    req_i = 1'b1; size_i = sz; signed_i = sg; form_i = fm;
    acc_i = a; dat_i = d; src_i = s;
    @(negedge clk);
    req_i = 1'b0;
    chk("R10", "valid", {31'd0, valid_o}, 32'd1);
    chk(rreg, "acc", acc_o, eacc);
    chk(rreg, "dat", dat_o, edat);
    chk(fm ? "R9" : "R7", "res", res_o, trunc[31:0]);
    chk(rov, "carry", {31'd0, flags_o[0]}, {31'd0, ov});
    chk(rov, "overflow", {31'd0, flags_o[11]}, {31'd0, ov});
    chk("R6", "parity", {31'd0, flags_o[2]}, {31'd0, ~(^p[7:0])});
    chk("R7", "zero", {31'd0, flags_o[6]}, {31'd0, trunc == 64'd0});
    chk("R7", "sign", {31'd0, flags_o[7]}, {31'd0, p[w-1]});
    chk("R8", "other bits", {16'd0, flags_o & 16'hF73A}, 32'd0);
    chk("R8", "aux carry", {31'd0, flags_o[4]}, 32'd0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; req_i = 1'b0; size_i = 2'd0; signed_i = 1'b0; form_i = 1'b0;
    acc_i = 32'hFFFF_FFFF; dat_i = 32'hFFFF_FFFF; src_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R11", "valid in reset", {31'd0, valid_o}, 32'd0);
    chk("R11", "acc in reset", acc_o, 32'd0);
    chk("R11", "dat in reset", dat_o, 32'd0);
    chk("R11", "res in reset", res_o, 32'd0);
    chk("R11", "flags in reset", {16'd0, flags_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_byte();
    run_op(2'd0, 1'b0, 1'b0, 32'hABCD_1207, 32'h5555_AAAA, 32'hFFFF_FF09); // R1 small
    run_op(2'd0, 1'b0, 1'b0, 32'h1234_56FF, 32'h0000_0001, 32'h0000_00FF); // R1 R4 all ones
    run_op(2'd0, 1'b1, 1'b0, 32'h1234_56FF, 32'h0000_0001, 32'h0000_00FF); // R5 -1*-1
    run_op(2'd0, 1'b1, 1'b0, 32'h0000_0080, 32'h0, 32'h0000_00FF);         // R5 -128*-1
    run_op(2'd0, 1'b1, 1'b0, 32'h0000_0040, 32'h0, 32'h0000_0002);         // R5 128 overflow
    run_op(2'd0, 1'b0, 1'b0, 32'hFFFF_FF00, 32'h0, 32'h0000_0033);         // R7 zero
  endtask

  task automatic test_word();
    run_op(2'd1, 1'b0, 1'b0, 32'hDEAD_0100, 32'hBEEF_0000, 32'h0000_0100); // R2 R4 spill
    run_op(2'd1, 1'b0, 1'b0, 32'h0000_FFFF, 32'hCAFE_1234, 32'h0000_FFFF); // R4 all ones
    run_op(2'd1, 1'b1, 1'b0, 32'h0000_FFFF, 32'hCAFE_1234, 32'h0000_FFFF); // R5 -1*-1
    run_op(2'd1, 1'b1, 1'b0, 32'h7777_8000, 32'h0, 32'h0000_FFFF);         // R5 min*-1
    run_op(2'd1, 1'b1, 1'b0, 32'h0000_FFFD, 32'h0, 32'h0000_0005);         // R5 -3*5 fits
  endtask

  task automatic test_dword();
    run_op(2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1111_1111, 32'hFFFF_FFFF); // R3 R4
    run_op(2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h1111_1111, 32'hFFFF_FFFF); // R5 -1*-1
    run_op(2'd2, 1'b1, 1'b0, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF);         // R5 min*-1
    run_op(2'd3, 1'b0, 1'b0, 32'h0001_0000, 32'h0, 32'h0001_0000);         // R3 code 3
    run_op(2'd2, 1'b0, 1'b0, 32'h0000_0000, 32'h2222_2222, 32'h1234_5678); // R7 zero
    run_op(2'd2, 1'b1, 1'b0, 32'h0000_0007, 32'h0, 32'hFFFF_FFFA);         // R7 sign
  endtask

  task automatic test_two_op();
    run_op(2'd1, 1'b0, 1'b1, 32'h1234_FFFF, 32'h9999_9999, 32'h0000_0003); // R9 signed forced
    run_op(2'd0, 1'b0, 1'b1, 32'h0000_0100, 32'h0, 32'h0000_0100);         // R9 byte as word
    run_op(2'd2, 1'b1, 1'b1, 32'h8000_0000, 32'h4444_4444, 32'hFFFF_FFFF); // R9 min*-1
    run_op(2'd2, 1'b0, 1'b1, 32'h0000_0000, 32'h0, 32'hFFFF_FFFF);         // R9 zero
  endtask

  task automatic test_hold();
    logic [31:0] a0, d0, r0;
    logic [15:0] f0;
    run_op(2'd1, 1'b0, 1'b0, 32'h0000_1234, 32'h0000_0000, 32'h0000_0010);
    a0 = acc_o; d0 = dat_o; r0 = res_o; f0 = flags_o;
    acc_i = 32'h5A5A_5A5A; dat_i = 32'hA5A5_A5A5; src_i = 32'h0F0F_0F0F;
    size_i = 2'd2; signed_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "valid idle", {31'd0, valid_o}, 32'd0);
    chk("R10", "acc held", acc_o, a0);
    chk("R10", "dat held", dat_o, d0);
    chk("R10", "res held", res_o, r0);
    chk("R10", "flags held", {16'd0, flags_o}, {16'd0, f0});
  endtask

  initial begin
    test_reset();
    test_byte();
    test_word();
    test_dword();
    test_two_op();
    test_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule